// File: doc/BRIEF.md
# Fault Response and Restart Controller

This controller sits between the voltage and input monitors and the per-rail sequencing engine. It reacts to four fault lines: output over-voltage, output under-voltage, input over-voltage and input under-voltage. Each fault line has its own 2-bit response code. A code may tell the controller to ignore the fault, or it may tell the controller to shut all rails down in reverse order and then try to bring them back up.

After a shutdown request, the controller waits until every rail reports that its power-good is low. If the delay setting is non-zero, it then waits a fixed number of clock cycles, set at elaboration time. It then asks the engine to sequence back up. A single retry setting and a single delay setting apply to every fault type. When the retry budget runs out, the controller stays locked. It leaves the lock only after all fault lines have cleared and the enable input has been taken low and then high again.

All pins are plain control and status levels or one-cycle pulses. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `fault_restart_ctrl`

## Requirements
- R1: A fault line whose response code is 00 causes no power-down request, no restart and no lock. Fault type t reads its code from bits [2t+1:2t] of `resp_codes`. The types are ordered 0 output OV, 1 output UV, 2 input OV, 3 input UV.
- R2: Response codes 01 and 11 behave like 00. In addition, `bad_resp` pulses for exactly one cycle, one cycle after that fault line rises.
- R3: While running with `enable_in` high, an active fault line coded 10 produces a one-cycle `pwr_down_req` pulse. A fault that is still present after a restart trips again.
- R4: With delay setting 0, once all `rail_pg` bits are low, `pwr_up_req` pulses for one cycle. The pulse comes 2 cycles after the `pwr_down_req` pulse when power-good is already low.
- R5: With delay setting 1 to 7, `pwr_up_req` comes RESTART_DLY+2 cycles after `pwr_down_req`. No restart is issued while any `rail_pg` bit stays high.
- R6: With retry setting 0, the first power-down leads straight to `locked_out` and no restart is issued.
- R7: With retry setting N from 1 to 6 and a persistent fault, exactly N restarts are issued, followed by lock.
- R8: With retry setting 7, the controller never locks and keeps restarting.
- R9: While locked, clearing the fault alone does not release the lock, and toggling `enable_in` while a fault is active does not release it either. The lock is released once both conditions hold: `enable_in` has gone low and is high again, and all fault lines are low.
- R10: The count of restart attempts returns to zero whenever `enable_in` is low, so a fresh retry budget is available after an enable toggle.
- R11: After reset, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_in | input | 1 | Sequencer enable level |
| fault_act | input | N_FAULTS | Fault levels, one per fault type |
| resp_codes | input | 2*N_FAULTS | Response code per fault type |
| retry_cfg | input | 3 | Global retry setting (7 = unlimited) |
| delay_cfg | input | 3 | Global delay setting (0 = none) |
| rail_pg | input | N_RAILS | Power-good of every rail |
| pwr_down_req | output | 1 | One-cycle reverse-order shutdown request |
| pwr_up_req | output | 1 | One-cycle re-sequence request |
| locked_out | output | 1 | Lock-out state |
| bad_resp | output | 1 | One-cycle flag for an invalid response code |

## Verification
The main function is driven with one persistent fault per fault type under every kind of response code. Codes 00, 01 and 11 must leave the rails alone, and only the invalid codes may raise the flag. Shutdown codes are paired with retry settings 0, 1, 3, 6 and 7, so that the counts of down and up pulses separate a correct budget from off-by-one errors and from a broken unlimited mode. Two further checks cover timing. Measuring the down-to-up distance with and without delay exposes the timer length. Holding power-good high shows whether the restart waits for the rails.

// File: rtl/frc_pkg.sv
package frc_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_SHUTDOWN_REQ,
    ST_WAIT_PG_LOW,
    ST_DELAY,
    ST_RESTART,
    ST_LOCKED
  } frc_state_e;

  localparam int          RETRY_W       = 3;
  localparam logic [1:0]  RESP_CONTINUE = 2'b00;
  localparam logic [1:0]  RESP_SHUTDOWN = 2'b10;
endpackage

// File: rtl/frc_resp_decode.sv
module frc_resp_decode #(
  parameter int N_FAULTS = 4
) (
  input  logic [2*N_FAULTS-1:0] resp_codes,
  output logic [N_FAULTS-1:0]   shut_mask,
  output logic [N_FAULTS-1:0]   inv_mask
);
  import frc_pkg::*;

  for (genvar g = 0; g < N_FAULTS; g++) begin : g_type
    logic [1:0] code;
    assign code         = resp_codes[2*g +: 2];
    assign shut_mask[g] = (code == RESP_SHUTDOWN);
    assign inv_mask[g]  = (code != RESP_SHUTDOWN) && (code != RESP_CONTINUE);
  end
endmodule

// File: rtl/frc_retry_budget.sv
module frc_retry_budget #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         exhausted
);
  localparam logic [W-1:0] FOREVER = '1;

  logic [W-1:0] used;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)             used <= '0;
    else if (inc && used != '1)    used <= used + 1'b1;
  end

  assign exhausted = (limit == '0) || ((limit != FOREVER) && (used >= limit));

  // R10: attempt count cleared while enable is low
  a_r10_clear_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (used == '0));
endmodule

// File: rtl/frc_delay_timer.sv
module frc_delay_timer #(
  parameter int DLY = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;
  localparam logic [CW-1:0] LOAD = CW'(DLY - 1);

  logic [CW-1:0] cnt;
  logic          running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= LOAD;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  assign done = running && (cnt == '0);

  // R5: countdown never exceeds the programmed length
  a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= LOAD));
endmodule

// File: rtl/fault_restart_ctrl.sv
module fault_restart_ctrl #(
  parameter int N_RAILS     = 8,
  parameter int N_FAULTS    = 4,
  parameter int RESTART_DLY = 1000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable_in,
  input  logic [N_FAULTS-1:0]   fault_act,
  input  logic [2*N_FAULTS-1:0] resp_codes,
  input  logic [2:0]            retry_cfg,
  input  logic [2:0]            delay_cfg,
  input  logic [N_RAILS-1:0]    rail_pg,
  output logic                  pwr_down_req,
  output logic                  pwr_up_req,
  output logic                  locked_out,
  output logic                  bad_resp
);
  import frc_pkg::*;

  frc_state_e state, state_nx;

  logic [N_FAULTS-1:0] shut_mask, inv_mask, fault_q;
  logic shut_hit, all_low, exhausted, tmr_start, tmr_done, en_seen_low;

  frc_resp_decode #(.N_FAULTS(N_FAULTS)) u_dec (
    .resp_codes (resp_codes),
    .shut_mask  (shut_mask),
    .inv_mask   (inv_mask)
  );

  frc_retry_budget #(.W(RETRY_W)) u_budget (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!enable_in),
    .inc       (state == ST_RESTART),
    .limit     (retry_cfg),
    .exhausted (exhausted)
  );

  frc_delay_timer #(.DLY(RESTART_DLY)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .done  (tmr_done)
  );

  assign shut_hit  = |(fault_act & shut_mask);
  assign all_low   = ~|rail_pg;
  assign tmr_start = (state == ST_WAIT_PG_LOW) && all_low && !exhausted && (delay_cfg != 3'd0);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:          if (enable_in && shut_hit) state_nx = ST_SHUTDOWN_REQ;
      ST_SHUTDOWN_REQ: state_nx = ST_WAIT_PG_LOW;
      ST_WAIT_PG_LOW:
        if (all_low) begin
          if (exhausted)              state_nx = ST_LOCKED;
          else if (delay_cfg == 3'd0) state_nx = ST_RESTART;
          else                        state_nx = ST_DELAY;
        end
      ST_DELAY:        if (tmr_done) state_nx = ST_RESTART;
      ST_RESTART:      state_nx = ST_RUN;
      ST_LOCKED:       if (en_seen_low && enable_in && (fault_act == '0)) state_nx = ST_RUN;
      default:         state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_RUN;
      fault_q     <= '0;
      bad_resp    <= 1'b0;
      en_seen_low <= 1'b0;
    end else begin
      state       <= state_nx;
      fault_q     <= fault_act;
      bad_resp    <= |(fault_act & ~fault_q & inv_mask);
      if (state != ST_LOCKED) en_seen_low <= 1'b0;
      else if (!enable_in)    en_seen_low <= 1'b1;
    end
  end

  assign pwr_down_req = (state == ST_SHUTDOWN_REQ);
  assign pwr_up_req   = (state == ST_RESTART);
  assign locked_out   = (state == ST_LOCKED);

  // R3: shutdown request is a single-cycle pulse
  a_r3_down_single: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_req |=> !pwr_down_req);

  // R2: invalid-code flag only follows an active fault line
  a_r2_bad_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
    bad_resp |-> $past(|fault_act));

  // R8: unlimited retry never enters lock-out
  a_r8_forever_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_PG_LOW && all_low && retry_cfg == 3'd7) |=> !locked_out);

  // R9: leaving lock-out needs enable high and every fault clear
  a_r9_lock_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_out) |-> ($past(enable_in) && ($past(fault_act) == '0)));
endmodule

// File: tb/fault_restart_ctrl_test.sv
`timescale 1ns/1ps
module fault_restart_ctrl_test;
  localparam int NR  = 8;
  localparam int NF  = 4;
  localparam int DLY = 8;
  localparam int WIN = 300;

  typedef struct packed {
    logic [1:0] ftype;
    logic [1:0] code;
    logic [2:0] retry;
    logic [2:0] dly;
    logic [3:0] downs;   // 15 means "at least 8"
    logic [3:0] ups;     // 15 means "at least 8"
    logic       lock;
    logic       bad;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{2'd0, 2'b00, 3'd3, 3'd0, 4'd0,  4'd0,  1'b0, 1'b0},  // R1
    '{2'd1, 2'b01, 3'd3, 3'd0, 4'd0,  4'd0,  1'b0, 1'b1},  // R2
    '{2'd2, 2'b11, 3'd2, 3'd1, 4'd0,  4'd0,  1'b0, 1'b1},  // R2
    '{2'd0, 2'b10, 3'd0, 3'd0, 4'd1,  4'd0,  1'b1, 1'b0},  // R6
    '{2'd1, 2'b10, 3'd1, 3'd0, 4'd2,  4'd1,  1'b1, 1'b0},  // R7
    '{2'd2, 2'b10, 3'd3, 3'd2, 4'd4,  4'd3,  1'b1, 1'b0},  // R7
    '{2'd3, 2'b10, 3'd6, 3'd7, 4'd7,  4'd6,  1'b1, 1'b0},  // R7
    '{2'd3, 2'b10, 3'd7, 3'd0, 4'd15, 4'd15, 1'b0, 1'b0},  // R8
    '{2'd0, 2'b10, 3'd7, 3'd4, 4'd15, 4'd15, 1'b0, 1'b0}   // R8
  };

  logic clk = 1'b0, rst_n = 1'b0, enable_in = 1'b0;
  logic [NF-1:0]   fault_act = '0;
  logic [2*NF-1:0] resp_codes = '0;
  logic [2:0]      retry_cfg = '0, delay_cfg = '0;
  logic [NR-1:0]   pg_m, rail_pg;
  logic pg_hold = 1'b0, pg_force_up = 1'b0;
  logic pwr_down_req, pwr_up_req, locked_out, bad_resp;

  int n_chk = 0, n_fail = 0;
  int nd, nu, nb, cyc, t_dn, t_up;
  logic cnt_en = 1'b0, finished = 1'b0;

  always #2.5 clk = ~clk;

  fault_restart_ctrl #(.N_RAILS(NR), .N_FAULTS(NF), .RESTART_DLY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .enable_in(enable_in), .fault_act(fault_act),
    .resp_codes(resp_codes), .retry_cfg(retry_cfg), .delay_cfg(delay_cfg),
    .rail_pg(rail_pg), .pwr_down_req(pwr_down_req), .pwr_up_req(pwr_up_req),
    .locked_out(locked_out), .bad_resp(bad_resp)
  );

  // Rail model: power-good drops on a shutdown request, returns on a restart
  always @(negedge clk) begin
    if (!rst_n || pg_force_up) pg_m <= '1;
    else if (pwr_down_req)     pg_m <= '0;
    else if (pwr_up_req)       pg_m <= '1;
  end
  assign rail_pg = pg_hold ? '1 : pg_m;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cnt_en) begin
      if (pwr_down_req) begin nd <= nd + 1; if (t_dn < 0) t_dn <= cyc; end
      if (pwr_up_req)   begin nu <= nu + 1; if (t_up < 0) t_up <= cyc; end
      if (bad_resp)     nb <= nb + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clr_counts();
    nd = 0; nu = 0; nb = 0; t_dn = -1; t_up = -1;
  endtask

  task automatic setup(input int ft, input logic [1:0] code, input logic [2:0] r, input logic [2:0] d);
    enable_in = 1'b0; fault_act = '0; pg_hold = 1'b0;
    resp_codes = '0; resp_codes[2*ft +: 2] = code;
    retry_cfg = r; delay_cfg = d;
    pg_force_up = 1'b1; tick(3); pg_force_up = 1'b0;
    enable_in = 1'b1; tick(2);
    clr_counts(); cnt_en = 1'b1;
  endtask

  function automatic string req_of(input vec_t v);
    if (v.code == 2'b00) return "R1";
    if (v.code != 2'b10) return "R2";
    if (v.retry == 3'd0) return "R6";
    if (v.retry == 3'd7) return "R8";
    return "R7";
  endfunction

  initial begin : watchdog
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cyc = 0; clr_counts();
    tick(4);
    // R11: reset state
    check("R11", pwr_down_req, 0, "down after reset");
    check("R11", pwr_up_req,   0, "up after reset");
    check("R11", locked_out,   0, "lock after reset");
    check("R11", bad_resp,     0, "bad after reset");
    rst_n = 1'b1; tick(2);

    // Table walk: R1 R2 R3 R6 R7 R8
    for (int i = 0; i < 9; i++) begin
      setup(VECS[i].ftype, VECS[i].code, VECS[i].retry, VECS[i].dly);
      fault_act[VECS[i].ftype] = 1'b1;
      tick(WIN);
      if (VECS[i].downs == 4'd15) begin
        check(req_of(VECS[i]), int'(nd >= 8), 1, "many downs");
        check(req_of(VECS[i]), int'(nu >= 8), 1, "many ups");
      end else begin
        check(req_of(VECS[i]), nd, VECS[i].downs, "down count (R3)");
        check(req_of(VECS[i]), nu, VECS[i].ups,   "up count");
      end
      check(req_of(VECS[i]), locked_out, VECS[i].lock, "lock state");
      check(req_of(VECS[i]), nb, VECS[i].bad, "bad flag pulses");
      cnt_en = 1'b0; fault_act = '0;
    end

    // R4: no delay, down-to-up distance 2
    setup(0, 2'b10, 3'd1, 3'd0);
    fault_act[0] = 1'b1; tick(60);
    check("R4", t_up - t_dn, 2, "down-to-up cycles, no delay");
    cnt_en = 1'b0;

    // R5: delay enabled, distance DLY+2
    setup(1, 2'b10, 3'd1, 3'd3);
    fault_act[1] = 1'b1; tick(60);
    check("R5", t_up - t_dn, DLY + 2, "down-to-up cycles, with delay");
    cnt_en = 1'b0;

    // R5: restart waits for every power-good to drop
    setup(2, 2'b10, 3'd1, 3'd0);
    pg_hold = 1'b1;
    fault_act[2] = 1'b1; tick(40);
    check("R5", nd, 1, "one down while pg held");
    check("R5", nu, 0, "no up while pg held");
    pg_hold = 1'b0; tick(60);
    check("R5", nu, 1, "up after pg released");
    check("R7", locked_out, 1, "locked after single retry");

    // R9: clearing fault alone keeps the lock
    fault_act = '0; tick(5);
    check("R9", locked_out, 1, "fault clear only");
    // R9: enable toggle with fault active keeps the lock
    fault_act[2] = 1'b1;
    enable_in = 1'b0; tick(3); enable_in = 1'b1; tick(5);
    check("R9", locked_out, 1, "toggle with fault active");
    fault_act = '0; tick(3);
    check("R9", locked_out, 0, "released after both");

    // R10: budget refreshed by the enable toggle
    clr_counts(); fault_act[2] = 1'b1; tick(100);
    check("R10", nu, 1, "restart available after toggle");
    check("R10", locked_out, 1, "locked again");
    cnt_en = 1'b0; fault_act = '0;

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule